// File: doc/BRIEF.md
# Pulse-per-second referenced event time stamper

The block measures when an external contact changes state, counted from the most recent pulse of a satellite pulse-per-second reference. A sub-second counter advances by one on every clock and is cleared by each reference pulse. Its value therefore always gives the time elapsed since the last second boundary. At 125 MHz one count is 8 ns, far finer than a millisecond. Software turns a count into a fraction of a second by dividing it by the clock frequency.

Both the reference pulse and the contact input are asynchronous. Each one passes through a two-flop synchroniser and then an edge detector. Every change of the contact, rising or falling, stores the counter value and the direction of the change, and raises a valid flag. The stored stamp stays put until the consumer acknowledges it. A change that arrives while a stamp is still held raises an overrun flag and is dropped. When a contact edge lands in the same cycle as a reference edge, the count from before the clear is stored and marked as belonging to the second that just ended. If no reference pulse arrives, the counter stops at a configurable ceiling and a lost-reference flag is raised.

Top module: `pps_event_stamper`

## Requirements
- R1: While reset is asserted and right after it is released, stamp_o, stamp_pol_o, stamp_prev_o, stamp_vld_o, overrun_o and pps_lost_o are all 0.
- R2: The counter advances by one per clock and is cleared by each synchronised rising edge of pps_i. An event whose input change is driven D clock cycles after a one-cycle pps_i pulse (D at least 1) stores stamp_o = D-1.
- R3: Both directions of change on evt_i are captured. stamp_pol_o is 1 for a low-to-high change and 0 for a high-to-low change.
- R4: A change on evt_i becomes visible on the outputs after the third rising clock edge that follows it, and not earlier.
- R5: stamp_vld_o stays 1 until ack_i is sampled high. An ack with no new event in the same cycle clears stamp_vld_o on the next edge.
- R6: An event that arrives while stamp_vld_o is 1 and ack_i is 0 sets overrun_o and leaves stamp_o and stamp_pol_o unchanged. overrun_o stays set until an ack.
- R7: When an event edge and a reference edge reach the capture stage in the same cycle, stamp_o holds the count from before the clear and stamp_prev_o is 1. In every other case stamp_prev_o is 0.
- R8: Without reference pulses the counter stops at MAX_CNT, and pps_lost_o rises one cycle after that. The next reference edge clears both the counter and pps_lost_o.
- R9: An ack sampled in the same cycle as a new event edge stores the new stamp, keeps stamp_vld_o at 1 and clears overrun_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_i | input | 1 | Asynchronous pulse-per-second reference |
| evt_i | input | 1 | Asynchronous contact input |
| ack_i | input | 1 | Consumer has taken the stamp (synchronous) |
| stamp_o | output | CNT_W | Counter value stored at the event |
| stamp_pol_o | output | 1 | Direction of the event: 1 rising, 0 falling |
| stamp_prev_o | output | 1 | Stamp belongs to the second that just ended |
| stamp_vld_o | output | 1 | A stamp is held |
| overrun_o | output | 1 | An event was dropped while a stamp was held |
| pps_lost_o | output | 1 | Counter stopped at its ceiling with no reference pulse |

## Verification
Both asynchronous inputs pass through three registers before they act: two synchroniser flops and the capture register or the counter clear. A stimulus driven on a falling clock edge is therefore expected to show on the outputs after the third rising edge. The acknowledge input is synchronous and takes effect on the next rising edge. The bench drives every input on falling edges and compares the outputs on falling edges against a cycle-by-cycle expected state built from the requirements. The directed cases count falling edges explicitly, so that both the early "not yet" sample and the due sample are checked.

// File: rtl/pps_stamp_pkg.sv
package pps_stamp_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  function automatic logic any_edge(input edge_t e);
    return e.rise | e.fall;
  endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 d_i,
  output logic                 lvl_o,
  output pps_stamp_pkg::edge_t edge_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign sh_d[g] = d_i;
      end else begin : g_rest
        assign sh_d[g] = sh_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[LAST];
    end
  end

  assign lvl_o       = sh_q[LAST];
  assign edge_o.rise = sh_q[LAST] & ~prev_q;
  assign edge_o.fall = ~sh_q[LAST] & prev_q;
endmodule

// File: rtl/subsec_counter.sv
module subsec_counter #(
  parameter int CNT_W   = 27,
  parameter int MAX_CNT = 125_000_099
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             lost_o
);
  localparam logic [CNT_W-1:0] CEIL = CNT_W'(MAX_CNT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lost_q, lost_d;
  logic             at_ceil;
  logic             cnt_en;

  assign at_ceil = (cnt_q == CEIL);
  assign cnt_en  = clear_i | ~at_ceil;

  always_comb begin
    cnt_d  = cnt_q;
    lost_d = lost_q;
    if (clear_i) begin
      cnt_d  = '0;
      lost_d = 1'b0;
    end else if (at_ceil) begin
      lost_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      lost_q <= lost_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign lost_o = lost_q;
endmodule

// File: rtl/stamp_hold.sv
module stamp_hold #(
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_edge_i,
  input  logic             evt_lvl_i,
  input  logic             pps_edge_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] stamp_o,
  output logic             pol_o,
  output logic             prev_o,
  output logic             vld_o,
  output logic             ovr_o
);
  logic [CNT_W-1:0] stamp_q;
  logic             pol_q, prev_q, vld_q, ovr_q;
  logic             vld_d, ovr_d;
  logic             load;

  assign load = evt_edge_i & (~vld_q | ack_i);

  always_comb begin
    vld_d = vld_q;
    ovr_d = ovr_q;
    if (load) begin
      vld_d = 1'b1;
      ovr_d = 1'b0;
    end else if (evt_edge_i) begin
      ovr_d = 1'b1;
    end else if (ack_i) begin
      vld_d = 1'b0;
      ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q <= '0;
      pol_q   <= 1'b0;
      prev_q  <= 1'b0;
      vld_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (load) begin
        stamp_q <= cnt_i;
        pol_q   <= evt_lvl_i;
        prev_q  <= pps_edge_i;
      end
      vld_q <= vld_d;
      ovr_q <= ovr_d;
    end
  end

  assign stamp_o = stamp_q;
  assign pol_o   = pol_q;
  assign prev_o  = prev_q;
  assign vld_o   = vld_q;
  assign ovr_o   = ovr_q;
endmodule

// File: rtl/pps_event_stamper.sv
module pps_event_stamper #(
  parameter int CNT_W     = 27,
  parameter int MAX_CNT   = 125_000_099,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps_i,
  input  logic             evt_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] stamp_o,
  output logic             stamp_pol_o,
  output logic             stamp_prev_o,
  output logic             stamp_vld_o,
  output logic             overrun_o,
  output logic             pps_lost_o
);
  import pps_stamp_pkg::*;

  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  edge_t      pps_e, evt_e;
  logic       pps_lvl, evt_lvl;
  logic       pps_edge, evt_edge;
  logic [CNT_W-1:0] cnt;

  edge_sync #(.STAGES(SYNC_STGS)) u_pps_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(pps_i), .lvl_o(pps_lvl), .edge_o(pps_e)
  );

  edge_sync #(.STAGES(SYNC_STGS)) u_evt_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(evt_i), .lvl_o(evt_lvl), .edge_o(evt_e)
  );

  assign pps_edge = pps_e.rise;
  assign evt_edge = any_edge(evt_e);

  subsec_counter #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .clear_i(pps_edge), .cnt_o(cnt), .lost_o(pps_lost_o)
  );

  stamp_hold #(.CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_sync_n),
    .evt_edge_i(evt_edge), .evt_lvl_i(evt_lvl), .pps_edge_i(pps_edge),
    .cnt_i(cnt), .ack_i(ack_i),
    .stamp_o(stamp_o), .pol_o(stamp_pol_o), .prev_o(stamp_prev_o),
    .vld_o(stamp_vld_o), .ovr_o(overrun_o)
  );
endmodule

// File: rtl/pps_stamp_chk.sv
module pps_stamp_chk #(
  parameter int CNT_W   = 27,
  parameter int MAX_CNT = 125_000_099
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pps_edge,
  input logic             evt_edge,
  input logic [CNT_W-1:0] cnt,
  input logic             ack_i,
  input logic [CNT_W-1:0] stamp_o,
  input logic             stamp_pol_o,
  input logic             stamp_vld_o,
  input logic             overrun_o,
  input logic             pps_lost_o
);
  // R2
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pps_edge |=> (cnt == '0));

  // R8
  cnt_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_CNT));

  // R8
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pps_lost_o && !pps_edge |=> pps_lost_o);

  // R5
  vld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_vld_o && !ack_i |=> stamp_vld_o);

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && !evt_edge |=> !stamp_vld_o);

  // R6
  stamp_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_vld_o && !ack_i |=> $stable(stamp_o) && $stable(stamp_pol_o));

  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o && !ack_i |=> overrun_o);

  // R6
  ovr_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> stamp_vld_o);
endmodule

bind pps_event_stamper pps_stamp_chk #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .pps_edge(pps_edge), .evt_edge(evt_edge),
  .cnt(cnt), .ack_i(ack_i), .stamp_o(stamp_o), .stamp_pol_o(stamp_pol_o),
  .stamp_vld_o(stamp_vld_o), .overrun_o(overrun_o), .pps_lost_o(pps_lost_o)
);

// File: tb/sim_pps_event_stamper.sv
`timescale 1ns/1ps
module sim_pps_event_stamper;
  localparam int CNT_W   = 12;
  localparam int MAX_CNT = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pps_i = 1'b0, evt_i = 1'b0, ack_i = 1'b0;
  logic [CNT_W-1:0] stamp_o;
  logic stamp_pol_o, stamp_prev_o, stamp_vld_o, overrun_o, pps_lost_o;

  int n_chk = 0, n_bad = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pps_event_stamper #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u0 (
    .clk(clk), .rst_n(rst_n), .pps_i(pps_i), .evt_i(evt_i), .ack_i(ack_i),
    .stamp_o(stamp_o), .stamp_pol_o(stamp_pol_o), .stamp_prev_o(stamp_prev_o),
    .stamp_vld_o(stamp_vld_o), .overrun_o(overrun_o), .pps_lost_o(pps_lost_o)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Expected state from the requirements, advanced once per rising edge
  logic mr1, mr2;
  logic p1, p2, pp, e1, e2, ep;
  logic [CNT_W-1:0] m_cnt, m_stamp;
  logic m_lost, m_pol, m_prev, m_vld, m_ovr;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic clr);
    if (clr) return '0;
    if (c == CNT_W'(MAX_CNT)) return c;
    return c + 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 <= 0; mr2 <= 0;
    end else begin
      mr1 <= 1; mr2 <= mr1;
    end
    if (!rst_n || !mr2) begin
      {p1, p2, pp, e1, e2, ep} <= '0;
      m_cnt <= '0; m_stamp <= '0;
      {m_lost, m_pol, m_prev, m_vld, m_ovr} <= '0;
    end else begin
      logic pe, ee;
      pe = p2 & ~pp;
      ee = e2 ^ ep;
      p1 <= pps_i; p2 <= p1; pp <= p2;
      e1 <= evt_i; e2 <= e1; ep <= e2;
      m_cnt <= next_count(m_cnt, pe);
      if (pe) m_lost <= 0;
      else if (m_cnt == CNT_W'(MAX_CNT)) m_lost <= 1;
      if (ee && (!m_vld || ack_i)) begin
        m_stamp <= m_cnt; m_pol <= e2; m_prev <= pe; m_vld <= 1; m_ovr <= 0;
      end else if (ee) begin
        m_ovr <= 1;
      end else if (ack_i) begin
        m_vld <= 0; m_ovr <= 0;
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      chk("R2 stamp", stamp_o, m_stamp);
      chk("R3 polarity", stamp_pol_o, m_pol);
      chk("R5 valid", stamp_vld_o, m_vld);
      chk("R6 overrun", overrun_o, m_ovr);
      chk("R7 prev-second tag", stamp_prev_o, m_prev);
      chk("R8 lost", pps_lost_o, m_lost);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flush();
    ack_i = 1; step(1); ack_i = 0; step(1);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    step(3);
    // R1 during reset
    chk("R1 vld in reset", stamp_vld_o, 0);
    chk("R1 stamp in reset", stamp_o, 0);
    rst_n = 1;
    step(4);
    // R1 after release
    chk("R1 vld", stamp_vld_o, 0);
    chk("R1 ovr", overrun_o, 0);
    chk("R1 lost", pps_lost_o, 0);
    chk("R1 prev", stamp_prev_o, 0);
    model_on = 1'b1;

    // R2: known delay after a reference pulse
    pps_i = 1; step(1); pps_i = 0;
    step(49);
    evt_i = 1;
    step(2);
    chk("R4 not yet visible", stamp_vld_o, 0);
    step(1);
    chk("R4 visible on third edge", stamp_vld_o, 1);
    chk("R2 stamp equals D-1", stamp_o, 49);
    chk("R3 rising polarity", stamp_pol_o, 1);
    chk("R7 tag clear", stamp_prev_o, 0);
    step(5);
    chk("R5 held without ack", stamp_vld_o, 1);

    // R6: falling edge while held is dropped
    evt_i = 0; step(3);
    chk("R6 overrun set", overrun_o, 1);
    chk("R6 stamp kept", stamp_o, 49);
    chk("R6 polarity kept", stamp_pol_o, 1);
    // R9: ack together with a new event edge
    evt_i = 1; step(2);
    ack_i = 1; step(1); ack_i = 0;
    chk("R9 valid kept", stamp_vld_o, 1);
    chk("R9 overrun cleared", overrun_o, 0);
    flush();
    chk("R5 cleared by ack", stamp_vld_o, 0);

    // R3: falling edge alone
    evt_i = 0; step(3);
    chk("R3 falling polarity", stamp_pol_o, 0);
    flush();

    // R7: coincident reference and event edges
    pps_i = 1; evt_i = 1; step(1); pps_i = 0;
    step(2);
    chk("R7 prev-second tag", stamp_prev_o, 1);
    flush();

    // R8: missing reference pulse
    step(MAX_CNT + 10);
    chk("R8 lost flag", pps_lost_o, 1);
    evt_i = 0; step(3);
    chk("R8 saturated stamp", stamp_o, MAX_CNT);
    flush();
    pps_i = 1; step(1); pps_i = 0; step(2);
    chk("R8 lost cleared", pps_lost_o, 0);

    // Random mix, compared every cycle against the expected state
    for (int i = 0; i < 40000; i++) begin
      pps_i = ($urandom_range(0, 399) == 0);
      if ($urandom_range(0, 29) == 0) evt_i = ~evt_i;
      ack_i = ($urandom_range(0, 7) == 0);
      step(1);
    end
    pps_i = 0; ack_i = 0;
    step(4);
    finish_run();
  end
endmodule